// File: doc/BRIEF.md
# I2C Slave Byte Buffer Controller

This block is the byte-buffer and handshake core of a serial display-data slave on a two-wire (I2C) bus. A CPU-side port gives a one-byte transmit holding register and a one-byte receive register. A small bit engine behind them watches the bus lines and detects START and STOP. It compares a 7-bit slave address and shifts bytes in and out, most significant bit first. It drives SDA only by pulling it low, through an output-enable.

The controller decides when the transmit holding register moves into the output shifter. This happens when the slave's address is matched with a read request, or at the end of a transmitted byte that the master acknowledged. A master NACK ends the read. SDA is released, and any byte the CPU has placed in the holding register stays there until the next addressing. Received bytes land in the receive register and raise a full flag. A byte that arrives while the register is still full is dropped and flagged as an overrun.

Top module: `i2c_slave_buf`

## Requirements
- R1: After reset the transmit holding register holds 0xFF, tx_empty is 1, rx_full and rx_ovf are 0 and sda_oe is 0. A read with no CPU write returns 0xFF.
- R2: When an address byte whose upper 7 bits equal own_addr and whose last bit is 1 (read) is received, the slave pulls SDA low during the 9th clock. It then moves the holding register into the shifter, which sets tx_empty, and sends that byte MSB first.
- R3: An address byte that does not match own_addr gets no ACK (SDA stays released on the 9th clock). Later data bytes in that transfer are neither acknowledged nor stored, and rx_full stays 0.
- R4: After a transmitted byte, if the master holds SDA low on the 9th clock (ACK), the holding register moves into the shifter and its contents are sent as the next byte.
- R5: If the master leaves SDA high on the 9th clock of a transmitted byte (NACK), the slave releases SDA and loads nothing. A byte written by the CPU stays pending with tx_empty at 0 until the next read addressing, which sends it.
- R6: With a matched write address (last bit 0), the slave pulls SDA low on the 9th clock of the address and of each data byte. Each complete byte is stored in rx_data and sets rx_full.
- R7: A one-cycle pulse on cpu_rx_rd clears rx_full and rx_ovf.
- R8: A byte that completes while rx_full is 1 is dropped. rx_data keeps the older byte and rx_ovf is set.
- R9: A CPU write (cpu_tx_wr with en high) loads cpu_tx_data into the holding register and clears tx_empty. If the same cycle also loads the shifter, the shifter gets the older value and tx_empty ends up 0.
- R10: While en is 0, CPU writes to the holding register are ignored, tx_empty keeps its value and the slave never drives SDA.
- R11: A START seen in any state, including a repeated START in mid-transfer, restarts address reception. A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable |
| own_addr | input | 7 | Slave address compared with the first 7 bits after START |
| cpu_tx_wr | input | 1 | Write strobe for the transmit holding register |
| cpu_tx_data | input | 8 | Data for the transmit holding register |
| cpu_rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 8 | Receive register |
| tx_empty | output | 1 | Holding register has been moved to the shifter |
| rx_full | output | 1 | Receive register holds an unread byte |
| rx_ovf | output | 1 | A byte was dropped because the receive register was full |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A bus master model runs read transfers with different mixes of ACK and NACK, and the CPU writes at set points between bytes. This shows whether a load follows an acknowledge, whether nothing is loaded after a NACK, and whether a pending byte is sent at the next addressing. Write transfers are tried with a matching address, a foreign address and back-to-back bytes left unread, which separates acceptance, rejection and overrun. A repeated START from write into read, and a pass with the enable low, show that address reception restarts and that disabled writes have no effect.

// File: rtl/i2c_slave_buf_pkg.sv
package i2c_slave_buf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_TACK,
    ST_RX,
    ST_RACK
  } eng_state_t;
endpackage

// File: rtl/i2c_slave_buf_sync.sv
module i2c_slave_buf_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '1;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_slave_buf_engine.sv
module i2c_slave_buf_engine
  import i2c_slave_buf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [DW-2:0] own_addr,
  input  logic [DW-1:0] tx_byte,
  output logic          load_now,
  output logic          rx_done,
  output logic [DW-1:0] rx_byte,
  output logic          sda_oe
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW-1);

  eng_state_t    state;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sh;
  logic          phase, rw, scl_q, sda_q;
  logic          rise, fall, start_ev, stop_ev;

  assign rise     = scl_s & ~scl_q;
  assign fall     = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  always_comb begin
    load_now = 1'b0;
    if (en && !start_ev && !stop_ev && fall && phase)
      load_now = (state == ST_AACK && rw) || (state == ST_TACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      phase   <= 1'b0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      rx_done <= 1'b0;
      rx_byte <= '0;
    end else begin
      rx_done <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        phase  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (load_now) begin
        sh     <= tx_byte;
        sda_oe <= ~tx_byte[DW-1];
        phase  <= 1'b0;
        bitcnt <= '0;
        state  <= ST_TX;
      end else begin
        case (state)
          ST_ADDR: if (rise) begin
            sh <= {sh[DW-2:0], sda_s};
            if (bitcnt == LAST) begin
              bitcnt <= '0;
              phase  <= 1'b0;
              rw     <= sda_s;
              state  <= (sh[DW-2:0] == own_addr) ? ST_AACK : ST_IDLE;
            end else bitcnt <= bitcnt + 1'b1;
          end
          ST_AACK, ST_RACK: if (fall) begin
            if (!phase) begin
              phase  <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              phase  <= 1'b0;
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: if (fall) begin
            if (bitcnt == LAST) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              phase  <= 1'b0;
              state  <= ST_TACK;
            end else begin
              sh     <= {sh[DW-2:0], 1'b0};
              sda_oe <= ~sh[DW-2];
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_TACK: if (rise && !phase) begin
            if (sda_s) state <= ST_IDLE;
            else phase <= 1'b1;
          end
          ST_RX: if (rise) begin
            sh <= {sh[DW-2:0], sda_s};
            if (bitcnt == LAST) begin
              bitcnt  <= '0;
              phase   <= 1'b0;
              rx_done <= 1'b1;
              rx_byte <= {sh[DW-2:0], sda_s};
              state   <= ST_RACK;
            end else bitcnt <= bitcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R10: a disabled engine never pulls the line
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);

  // R5: a NACK seen in the acknowledge slot leaves the line released and idle
  a_r5_nack_releases: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_TACK && rise && !phase && sda_s && !start_ev && !stop_ev)
    |=> (!sda_oe && state == ST_IDLE));

  // R11: a STOP always leads to an idle, released slave
  a_r11_stop_idle: assert property (@(posedge clk) disable iff (rst)
    (en && stop_ev && !start_ev) |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: rtl/i2c_slave_buf.sv
module i2c_slave_buf #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-2:0] own_addr,
  input  logic          cpu_tx_wr,
  input  logic [DW-1:0] cpu_tx_data,
  input  logic          cpu_rx_rd,
  output logic [DW-1:0] rx_data,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_ovf,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe
);
  logic [1:0]    line_s;
  logic [DW-1:0] tx_hold;
  logic          load_now, rx_done, wr_ok, accept;
  logic [DW-1:0] rx_byte;

  i2c_slave_buf_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(line_s)
  );

  i2c_slave_buf_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .en(en),
    .scl_s(line_s[1]), .sda_s(line_s[0]),
    .own_addr(own_addr), .tx_byte(tx_hold),
    .load_now(load_now), .rx_done(rx_done), .rx_byte(rx_byte),
    .sda_oe(sda_oe)
  );

  assign wr_ok  = cpu_tx_wr & en;
  assign accept = rx_done & (~rx_full | cpu_rx_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold  <= '1;
      tx_empty <= 1'b1;
    end else begin
      if (wr_ok) begin
        tx_hold  <= cpu_tx_data;
        tx_empty <= 1'b0;
      end else if (load_now) tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_ovf  <= 1'b0;
    end else begin
      if (accept) begin
        rx_data <= rx_byte;
        rx_full <= 1'b1;
      end else if (cpu_rx_rd) rx_full <= 1'b0;
      if (cpu_rx_rd) rx_ovf <= 1'b0;
      else if (rx_done && rx_full) rx_ovf <= 1'b1;
    end
  end

  // R2: moving the holding byte to the shifter marks it empty
  a_r2_load_sets_empty: assert property (@(posedge clk) disable iff (rst)
    (load_now && !wr_ok) |=> tx_empty);

  // R9: a CPU write always leaves a pending byte
  a_r9_write_clears_empty: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (!tx_empty && tx_hold == $past(cpu_tx_data)));

  // R10: writes while disabled change nothing
  a_r10_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (cpu_tx_wr && !en && !load_now) |=> ($stable(tx_hold) && $stable(tx_empty)));

  // R6: a received byte in an empty register is stored and flagged
  a_r6_store_byte: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_full) |=> (rx_full && rx_data == $past(rx_byte)));

  // R7: a CPU read with no new byte empties the register
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (cpu_rx_rd && !rx_done) |=> (!rx_full && !rx_ovf));

  // R8: overrun keeps the old byte and raises the flag
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_full && !cpu_rx_rd) |=> (rx_ovf && $stable(rx_data)));
endmodule

// File: tb/i2c_slave_buf_tb_top.sv
`timescale 1ns/1ps
module i2c_slave_buf_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h37;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic cpu_tx_wr = 1'b0, cpu_rx_rd = 1'b0;
  logic [7:0] cpu_tx_data = 8'h00;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] rx_data;
  logic tx_empty, rx_full, rx_ovf, sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;
  logic [7:0] rx_exp_q[$];

  always #2.5 clk = ~clk;

  i2c_slave_buf dut_i (
    .clk(clk), .rst(rst), .en(en), .own_addr(ADDR),
    .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data), .cpu_rx_rd(cpu_rx_rd),
    .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  // driver side of the transmit scoreboard: expected byte passed in
  task automatic get_byte(input logic master_ack, input logic [7:0] exp, input string req);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(master_ack);
    check(req, d, exp);
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk); cpu_tx_wr = 1'b1; cpu_tx_data = d;
    @(negedge clk); cpu_tx_wr = 1'b0;
  endtask

  task automatic cpu_read();
    @(negedge clk); cpu_rx_rd = 1'b1;
    @(negedge clk); cpu_rx_rd = 1'b0;
  endtask

  // monitor: pops expected receive bytes as rx_full rises
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_full === 1'b1 && !prev) begin
        if (rx_exp_q.size() == 0) check("R6 unexpected byte", rx_data, 8'hxx);
        else check("R6 received byte", rx_data, rx_exp_q.pop_front());
      end
      prev = (rx_full === 1'b1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    wq(4); @(negedge clk); rst = 1'b0; wq(4);
    @(negedge clk);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_full", rx_full, 0);
    check("R1 rx_ovf", rx_ovf, 0);
    check("R1 sda_oe", sda_oe, 0);

    // R1: untouched register reads as 0xFF
    bus_start(); put_byte({ADDR, 1'b1}, ack); check("R2 addr ack", ack, 0);
    get_byte(1'b1, 8'hFF, "R1 reset data");
    bus_stop();

    // R9, R2, R4, R5
    cpu_write(8'h3C); @(negedge clk); check("R9 write clears empty", tx_empty, 0);
    bus_start(); put_byte({ADDR, 1'b1}, ack); check("R2 addr ack", ack, 0);
    @(negedge clk); check("R2 load sets empty", tx_empty, 1);
    cpu_write(8'hA5);
    get_byte(1'b0, 8'h3C, "R2 first byte");
    cpu_write(8'h5A);
    get_byte(1'b1, 8'hA5, "R4 byte after ack");
    @(negedge clk); check("R5 released after nack", sda_oe, 0);
    check("R5 pending stays", tx_empty, 0);
    bus_stop();
    @(negedge clk); check("R5 pending after stop", tx_empty, 0);
    bus_start(); put_byte({ADDR, 1'b1}, ack); check("R5 readdress ack", ack, 0);
    @(negedge clk); check("R5 pending loaded", tx_empty, 1);
    get_byte(1'b1, 8'h5A, "R5 pending byte sent");
    bus_stop();

    // R3: foreign address
    bus_start(); put_byte({ADDR ^ 7'h01, 1'b0}, ack); check("R3 no addr ack", ack, 1);
    put_byte(8'h66, ack); check("R3 no data ack", ack, 1);
    bus_stop(); @(negedge clk); check("R3 nothing stored", rx_full, 0);

    // R6, R8, R7
    rx_exp_q.push_back(8'h81);
    bus_start(); put_byte({ADDR, 1'b0}, ack); check("R6 write addr ack", ack, 0);
    put_byte(8'h81, ack); check("R6 data ack", ack, 0);
    @(negedge clk); check("R6 full", rx_full, 1);
    put_byte(8'h42, ack); check("R6 data ack second", ack, 0);
    @(negedge clk); check("R8 old byte kept", rx_data, 8'h81);
    check("R8 overrun flag", rx_ovf, 1);
    bus_stop();
    cpu_read(); @(negedge clk);
    check("R7 full cleared", rx_full, 0);
    check("R7 overrun cleared", rx_ovf, 0);

    // R11: write then repeated start into read
    rx_exp_q.push_back(8'h17);
    bus_start(); put_byte({ADDR, 1'b0}, ack); check("R11 addr ack", ack, 0);
    put_byte(8'h17, ack); check("R11 data ack", ack, 0);
    bus_start(); put_byte({ADDR, 1'b1}, ack); check("R11 restart addr ack", ack, 0);
    get_byte(1'b1, 8'h5A, "R11 read after restart");
    bus_stop(); @(negedge clk); check("R11 idle after stop", sda_oe, 0);
    cpu_read();

    // R10: disabled
    @(negedge clk); en = 1'b0;
    cpu_write(8'h99); @(negedge clk); check("R10 write ignored", tx_empty, 1);
    bus_start(); put_byte({ADDR, 1'b1}, ack); check("R10 no ack when off", ack, 1);
    bus_stop();
    @(negedge clk); en = 1'b1; wq(4);
    bus_start(); put_byte({ADDR, 1'b1}, ack); check("R10 ack when on", ack, 0);
    get_byte(1'b1, 8'h5A, "R10 old data kept");
    bus_stop();

    check("R6 scoreboard drained", 8'(rx_exp_q.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule